// File: doc/BRIEF.md
# DRAM Mode Register Command Unit

This block lets a host issue single mode register reads and writes to a DRAM controller's command path through a small register window. The host puts the mode register address and write data into one control register. It then writes the rank and transfer type into a second control register with the start bit set. The unit presents one command on a valid/ready port. While that command is outstanding, the unit reports busy.

For a read, the unit waits for the returned byte on a data-return strobe. It stores that byte and raises a sticky valid flag. The flag stays set until software clears it through the read status register. DRAM timing and the PHY are outside the block: the command port and the return strobe stand in for them.

Register word indices on `reg_addr`:

| Index | Register |
|---|---|
| 0 | CTRL0 |
| 1 | CTRL1 |
| 2 | STATUS |
| 3 | RDSTAT |
| 4 | RDDATA |

Reads of any other index return zero.

Top module: `mrcmd_unit`

## Requirements
- R1: After reset, every register reads zero, `cmd_valid` is 0 and STATUS bit 0 (busy) is 0.
- R2: A write to CTRL0 (index 0) with bit 31 set while idle launches a command. The command takes its type from bit 0 (1 = read, 0 = write) and its rank from bits starting at 4. It takes the MR address from CTRL1[15:8] and the write data from CTRL1[7:0]. From the next cycle, `cmd_valid` is 1 and STATUS bit 0 reads 1.
- R3: CTRL0 bit 31 reads back 1 while the command waits on the port. It reads 0, and `cmd_valid` is 0, from the cycle after `cmd_valid` and `cmd_ready` are both high.
- R4: For a write command, busy falls in the cycle after the command is accepted.
- R5: For a read command, busy stays 1 after acceptance until `rd_ret_valid` is seen. From the next cycle, busy is 0, RDSTAT bit 3 is 1 and RDDATA[7:0] holds the returned byte.
- R6: While busy is 1, writes to CTRL0 (including launch requests) and to CTRL1 are ignored. The outstanding command and its register readback are unchanged.
- R7: A write to RDSTAT (index 3) with bit 2 or bit 0 set clears bit 3 in the next cycle. RDDATA keeps the last captured byte.
- R8: A `rd_ret_valid` pulse while no read is awaiting data is ignored. RDSTAT bit 3 and RDDATA are unchanged.
- R9: While `cmd_valid` waits for `cmd_ready`, the command fields on the port stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| cmd_valid | output | 1 | Command request valid |
| cmd_ready | input | 1 | Command accepted by the controller |
| cmd_read | output | 1 | 1 = mode register read, 0 = write |
| cmd_rank | output | RANK_W | Target rank |
| cmd_mraddr | output | 8 | Mode register address |
| cmd_mrdata | output | 8 | Mode register write data |
| rd_ret_valid | input | 1 | Returned read byte is valid |
| rd_ret_data | input | 8 | Returned read byte |

## Verification
A vector table mixes writes and reads across all ranks. The table pairs different address and data bytes with acceptance delays from zero to several cycles. This separates correct field routing from swapped or shifted fields. It also separates handshake-driven busy release from a fixed-latency release. Directed cases cover several behaviours:
- a second launch and a CTRL1 rewrite while busy, which shows whether the outstanding command is protected;
- a stray data-return strobe while idle;
- clearing the sticky flag with each of the two clear bits, which shows that clearing leaves the captured byte intact.

// File: rtl/mrcmd_pkg.sv
// Shared register indices and field positions for the mode register command unit.
package mrcmd_pkg;
    localparam int REG_AW = 3;
    localparam logic [REG_AW-1:0] IDX_CTRL0  = 3'd0;
    localparam logic [REG_AW-1:0] IDX_CTRL1  = 3'd1;
    localparam logic [REG_AW-1:0] IDX_STATUS = 3'd2;
    localparam logic [REG_AW-1:0] IDX_RDSTAT = 3'd3;
    localparam logic [REG_AW-1:0] IDX_RDDATA = 3'd4;

    localparam int MR_W      = 8;
    localparam int START_BIT = 31;
    localparam int TYPE_BIT  = 0;
    localparam int RANK_LSB  = 4;
    localparam int MRA_LSB   = 8;
    localparam int VALID_BIT = 3;
    localparam int CLR_BIT   = 2;
    localparam int ARM_BIT   = 0;
endpackage

// File: rtl/mrcmd_ctrl.sv
// Control registers, command launch and busy tracking.
// Assumes: the register bus writes one word per cycle, and cap_pulse only
// occurs while rd_wait is high.
module mrcmd_ctrl
    import mrcmd_pkg::*;
#(
    parameter int RANK_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    input  logic                  cmd_ready,
    input  logic                  cap_pulse,
    output logic                  cmd_valid,
    output logic                  cmd_read,
    output logic [RANK_W-1:0]     cmd_rank,
    output logic [MR_W-1:0]       cmd_mraddr,
    output logic [MR_W-1:0]       cmd_mrdata,
    output logic                  busy,
    output logic                  rd_wait
);
    logic ctrl0_we, ctrl1_we, launch, accept;

    // Decode register writes; all control writes are blocked while busy.
    always_comb begin
        ctrl0_we = reg_we && (reg_addr == IDX_CTRL0) && !busy;
        ctrl1_we = reg_we && (reg_addr == IDX_CTRL1) && !busy;
        launch   = ctrl0_we && reg_wdata[START_BIT];
        accept   = cmd_valid && cmd_ready;
    end

    // Hold the command fields, written only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_read   <= 1'b0;
            cmd_rank   <= '0;
            cmd_mraddr <= '0;
            cmd_mrdata <= '0;
        end else begin
            if (ctrl0_we) begin
                cmd_read <= reg_wdata[TYPE_BIT];
                cmd_rank <= reg_wdata[RANK_LSB +: RANK_W];
            end
            if (ctrl1_we) begin
                cmd_mraddr <= reg_wdata[MRA_LSB +: MR_W];
                cmd_mrdata <= reg_wdata[0 +: MR_W];
            end
        end
    end

    // Track the start bit, the busy flag and whether read data is awaited.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            busy      <= 1'b0;
            rd_wait   <= 1'b0;
        end else if (launch) begin
            cmd_valid <= 1'b1;
            busy      <= 1'b1;
        end else begin
            if (accept) begin
                cmd_valid <= 1'b0;
                if (cmd_read) rd_wait <= 1'b1;
                else          busy    <= 1'b0;
            end
            if (cap_pulse) begin
                rd_wait <= 1'b0;
                busy    <= 1'b0;
            end
        end
    end

    // R2
    // cmd_valid_busy_chk
    cmd_valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);
    // R3
    // start_clear_chk
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !cmd_valid);
    // R4
    // wr_done_chk
    wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cmd_read) |=> !busy);
    // R6
    // busy_hold_chk
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cmd_rank) && $stable(cmd_mraddr) && $stable(cmd_mrdata) && $stable(cmd_read)));
    // R9
    // cmd_stable_chk
    cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_mraddr) && $stable(cmd_mrdata)));
endmodule

// File: rtl/mrcmd_rdcap.sv
// Read data capture and the sticky read-valid flag with its software clear.
// Assumes: rd_ret_valid counts only while rd_wait is high; a capture in
// the same cycle as a clear wins.
module mrcmd_rdcap
    import mrcmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    input  logic               rd_wait,
    input  logic               rd_ret_valid,
    input  logic [MR_W-1:0]    rd_ret_data,
    output logic               cap_pulse,
    output logic               rd_valid,
    output logic [MR_W-1:0]    rd_data
);
    logic clr_req;

    // Qualify the return strobe and decode the clear request.
    always_comb begin
        cap_pulse = rd_wait && rd_ret_valid;
        clr_req   = reg_we && (reg_addr == IDX_RDSTAT)
                    && (reg_wdata[CLR_BIT] || reg_wdata[ARM_BIT]);
    end

    // Capture the returned byte and maintain the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else if (cap_pulse) begin
            rd_valid <= 1'b1;
            rd_data  <= rd_ret_data;
        end else if (clr_req) begin
            rd_valid <= 1'b0;
        end
    end

    // R5
    // capture_chk
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> (rd_valid && rd_data == $past(rd_ret_data)));
    // R7
    // clear_chk
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !cap_pulse) |=> (!rd_valid && $stable(rd_data)));
    // R8
    // stray_ret_chk
    stray_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ret_valid && !rd_wait) |=> $stable(rd_data));
endmodule

// File: rtl/mrcmd_unit.sv
// Top of the mode register command unit: wires the control block to the
// read-capture block and provides the register read mux.
// Assumes: 4 + RANK_W <= 31 so the rank field stays clear of the start bit.
module mrcmd_unit
    import mrcmd_pkg::*;
#(
    parameter int RANK_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic               cmd_read,
    output logic [RANK_W-1:0]  cmd_rank,
    output logic [7:0]         cmd_mraddr,
    output logic [7:0]         cmd_mrdata,
    input  logic               rd_ret_valid,
    input  logic [7:0]         rd_ret_data
);
    logic busy, rd_wait, cap_pulse, rd_valid;
    logic [MR_W-1:0] rd_data;

    mrcmd_ctrl #(.RANK_W(RANK_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cmd_ready(cmd_ready), .cap_pulse(cap_pulse),
        .cmd_valid(cmd_valid), .cmd_read(cmd_read), .cmd_rank(cmd_rank),
        .cmd_mraddr(cmd_mraddr), .cmd_mrdata(cmd_mrdata),
        .busy(busy), .rd_wait(rd_wait)
    );

    mrcmd_rdcap u_rdcap (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_wait(rd_wait), .rd_ret_valid(rd_ret_valid),
        .rd_ret_data(rd_ret_data), .cap_pulse(cap_pulse),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // Select the register word addressed by reg_addr.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            IDX_CTRL0: begin
                reg_rdata[START_BIT]            = cmd_valid;
                reg_rdata[RANK_LSB +: RANK_W]   = cmd_rank;
                reg_rdata[TYPE_BIT]             = cmd_read;
            end
            IDX_CTRL1: begin
                reg_rdata[MRA_LSB +: MR_W] = cmd_mraddr;
                reg_rdata[0 +: MR_W]       = cmd_mrdata;
            end
            IDX_STATUS: reg_rdata[0]         = busy;
            IDX_RDSTAT: reg_rdata[VALID_BIT] = rd_valid;
            IDX_RDDATA: reg_rdata[0 +: MR_W] = rd_data;
            default:    reg_rdata            = '0;
        endcase
    end

    // R1
    // reset_idle_chk
    reset_idle_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!cmd_valid && !busy && !rd_valid));
endmodule

// File: tb/test_mrcmd_unit.sv
module test_mrcmd_unit;
    localparam int CLK_PERIOD = 10;
    localparam int RANK_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic cmd_valid, cmd_read;
    logic cmd_ready = 1'b0;
    logic [RANK_W-1:0] cmd_rank;
    logic [7:0] cmd_mraddr, cmd_mrdata;
    logic rd_ret_valid = 1'b0;
    logic [7:0] rd_ret_data = '0;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mrcmd_unit #(.RANK_W(RANK_W)) i_mrcmd_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_read(cmd_read), .cmd_rank(cmd_rank),
        .cmd_mraddr(cmd_mraddr), .cmd_mrdata(cmd_mrdata),
        .rd_ret_valid(rd_ret_valid), .rd_ret_data(rd_ret_data)
    );

    // Vector: {read(1), rank(2), mraddr(8), wdata(8), retbyte(8), ready_delay(4)}
    localparam int NV = 6;
    localparam logic [30:0] VEC [NV] = '{
        {1'b0, 2'd0, 8'h01, 8'h5A, 8'h00, 4'd0},
        {1'b1, 2'd1, 8'h05, 8'h00, 8'hC3, 4'd2},
        {1'b0, 2'd3, 8'hFE, 8'hA5, 8'h00, 4'd5},
        {1'b1, 2'd2, 8'h18, 8'h00, 8'h3C, 4'd0},
        {1'b1, 2'd3, 8'h80, 8'h00, 8'hFF, 4'd3},
        {1'b0, 2'd1, 8'h7F, 8'h01, 8'h00, 4'd1}
    };

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, v);
        chk(v == exp, tag, v, exp);
    endtask

    task automatic pulse_ret(input logic [7:0] b);
        rd_ret_valid = 1'b1; rd_ret_data = b;
        @(negedge clk);
        rd_ret_valid = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_err++;
                $display("FAIL watchdog: actual %0d expected below 100000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 5; a++) rd_chk(3'(a), 32'h0, "R1 reg after reset");
        chk(cmd_valid == 1'b0, "R1 cmd_valid", {31'b0, cmd_valid}, 32'h0);

        // Table walk: R2 R3 R4 R5 R7 R9
        for (int i = 0; i < NV; i++) begin
            logic r; logic [1:0] rk; logic [7:0] ma, md, rb; logic [3:0] dly;
            {r, rk, ma, md, rb, dly} = VEC[i];
            wr(3'd1, {16'h0, ma, md});
            c0 = 32'h8000_0000 | (32'(rk) << 4) | 32'(r);
            wr(3'd0, c0);
            chk(cmd_valid && cmd_read == r && cmd_rank == rk && cmd_mraddr == ma && cmd_mrdata == md,
                "R2 command fields", {cmd_valid, 5'b0, cmd_read, cmd_rank, 8'h0, cmd_mraddr, cmd_mrdata},
                {1'b1, 5'b0, r, rk, 8'h0, ma, md});
            rd_chk(3'd2, 32'h1, "R2 busy after launch");
            rd_chk(3'd0, c0, "R3 start bit pending");
            for (int k = 0; k < dly; k++) begin
                @(negedge clk);
                chk(cmd_valid && cmd_mraddr == ma && cmd_mrdata == md, "R9 held while not ready",
                    {cmd_valid, 15'b0, cmd_mraddr, cmd_mrdata}, {1'b1, 15'b0, ma, md});
            end
            cmd_ready = 1'b1;
            @(negedge clk);
            cmd_ready = 1'b0;
            chk(!cmd_valid, "R3 cmd_valid after accept", {31'b0, cmd_valid}, 32'h0);
            rd_chk(3'd0, c0 & 32'h7FFF_FFFF, "R3 start bit cleared");
            if (!r) begin
                rd_chk(3'd2, 32'h0, "R4 busy after write accept");
            end else begin
                rd_chk(3'd2, 32'h1, "R5 busy until data");
                pulse_ret(rb);
                rd_chk(3'd2, 32'h0, "R5 busy after data");
                rd_chk(3'd3, 32'h8, "R5 valid flag");
                rd_chk(3'd4, {24'h0, rb}, "R5 read byte");
                wr(3'd3, 32'h4);
                rd_chk(3'd3, 32'h0, "R7 clear by bit 2");
                rd_chk(3'd4, {24'h0, rb}, "R7 byte kept");
            end
        end

        // R6 launch and CTRL1 rewrite while busy are ignored
        wr(3'd1, 32'h0000_2211);
        wr(3'd0, 32'h8000_0010);
        wr(3'd1, 32'h0000_9988);
        wr(3'd0, 32'h8000_0031);
        chk(cmd_rank == 2'd1 && !cmd_read && cmd_mraddr == 8'h22 && cmd_mrdata == 8'h11,
            "R6 command untouched", {cmd_read, 7'b0, 6'b0, cmd_rank, cmd_mraddr, cmd_mrdata},
            {8'h0, 8'h01, 8'h22, 8'h11});
        rd_chk(3'd1, 32'h0000_2211, "R6 CTRL1 readback");
        rd_chk(3'd0, 32'h8000_0010, "R6 CTRL0 readback");
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        rd_chk(3'd2, 32'h0, "R6 busy released");

        // R8 stray data return while idle (last captured byte 0xFF, flag cleared)
        pulse_ret(8'h42);
        rd_chk(3'd3, 32'h0, "R8 flag unchanged");
        rd_chk(3'd4, 32'h0000_00FF, "R8 byte unchanged");

        // R7 clear through bit 0
        wr(3'd1, 32'h0000_0700);
        wr(3'd0, 32'h8000_0001);
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        pulse_ret(8'h96);
        rd_chk(3'd3, 32'h8, "R5 valid before arm write");
        wr(3'd3, 32'h1);
        rd_chk(3'd3, 32'h0, "R7 clear by bit 0");
        rd_chk(3'd4, 32'h0000_0096, "R7 byte kept after arm");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule